// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block is the interrupt masking stage of a USB host controller. It holds a 32-bit enable mask that software can never write whole: one write port turns on every mask bit written as 1, and a second, independent write port turns off every mask bit written as 1. Bit 31 of the mask is a master switch that gates every interrupt source. Bit 30 and bits 6 down to 0 enable the individual sources. In descending order these are ownership change, root hub status change, frame number overflow, unrecoverable error, resume detect, start of frame, done-queue writeback and scheduling overrun.

Beside the mask sits an interrupt status register. Single-cycle event pulses from the rest of the controller set its bits. Software clears them by writing ones. The status register and the mask can both be read back through one select input.

A single registered interrupt request line is raised when a status bit and its enable bit are both set and the master bit is set as well.

Top module: `usb_irq_mask_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask, the status register and `irq_o` are all 0.
- R2: When `en_set_we` is high, each mask bit whose `en_set_data` bit is 1 becomes 1 on the next clock edge. Each bit written as 0 keeps its value. This includes the master bit 31.
- R3: When `en_clr_we` is high, each mask bit whose `en_clr_data` bit is 1 becomes 0 on the next clock edge. Each bit written as 0 keeps its value.
- R4: If the set port and the clear port both write 1 to the same mask bit in the same cycle, that bit ends up 0.
- R5: Bits 29 to 7 of both the mask and the status register ignore writes and events, and always read as 0. Bit 31 of the status register behaves the same way.
- R6: `irq_o` is 0 whenever master bit 31 of the mask is 0, whatever the status and source enable bits hold.
- R7: A 1 on bit 30 or on any of bits 6 to 0 of `evt_i` sets that status bit on the next edge. The bit then stays set until software clears it.
- R8: With `st_clr_we` high, each status bit written as 1 in `st_clr_data` becomes 0 on the next edge. If an event pulse arrives on the same bit in the same cycle, the event wins and the bit stays 1.
- R9: `irq_o` is registered. On each clock edge it takes the value (status AND mask is nonzero) AND (mask bit 31 is 1), computed from the register values held before that edge.
- R10: `rd_data` is combinational. It shows the status register when `rd_sel` is 0 and the mask when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set_we | input | 1 | Write strobe of the mask set port |
| en_set_data | input | 32 | Ones mark mask bits to turn on |
| en_clr_we | input | 1 | Write strobe of the mask clear port |
| en_clr_data | input | 32 | Ones mark mask bits to turn off |
| st_clr_we | input | 1 | Write strobe for clearing status bits |
| st_clr_data | input | 32 | Ones mark status bits to clear |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit |
| rd_sel | input | 1 | Read select: 0 status, 1 mask |
| rd_data | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench writes the same mask bit through both ports in one cycle. A design that let the set port win would leave that bit at 1. It fires an event in the same cycle that software clears that status bit. A design with the priority reversed would lose the event. It writes all-ones patterns to the reserved positions through both mask ports, through the status clear and on `evt_i`. A leaky design would read back nonzero bits 29 to 7. The bench also holds pending, enabled sources while the master bit is 0, and tracks the one-cycle lag of `irq_o` after each change. A request that ignored the master bit, or one driven straight from the registers, would show up one cycle off or when it should stay low.

// File: rtl/usb_irq_mask_pkg.sv
// Package: shared constants for the interrupt enable set/clear controller.
// Assumes a 32-bit register width with the master enable in the top bit.
package usb_irq_mask_pkg;
    localparam int          REG_W      = 32;
    localparam int          MASTER_BIT = 31;
    // Implemented interrupt sources: bit 30 and bits 6..0.
    localparam logic [31:0] SRC_BITS   = 32'h4000_007F;
    // Mask bits that exist: sources plus the master enable.
    localparam logic [31:0] MASK_BITS  = SRC_BITS | (32'h1 << MASTER_BIT);

    typedef enum logic {
        RD_STATUS = 1'b0,
        RD_ENABLE = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/irq_enable_reg.sv
// Module: irq_enable_reg
// Holds the interrupt enable mask. Software reaches it only through a
// write-1-to-set port and a write-1-to-clear port. Clear wins a collision.
// Assumes: IMPL_MASK marks the bits that exist; all other bits are
// constant 0 and have no storage.
module irq_enable_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_data,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] mask_q
);
    localparam logic [W-1:0] UNIMPL = ~IMPL_MASK;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic bit_q;
            // Per-bit update: reset, then clear priority, then set.
            always_ff @(posedge clk) begin
                if (!rst_n)                    bit_q <= 1'b0;
                else if (clr_we && clr_data[b]) bit_q <= 1'b0;
                else if (set_we && set_data[b]) bit_q <= 1'b1;
            end
            assign mask_q[b] = bit_q;
        end else begin : g_rsvd
            assign mask_q[b] = 1'b0;
        end
    end

    // Clear port bits are zero after the edge (R3, R4).
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_q & $past(clr_data)) == '0));

    // Set-only bits become one after the edge (R2).
    assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((mask_q & $past(set_data & IMPL_MASK)) == $past(set_data & IMPL_MASK)));

    // With no write, the mask holds (R2).
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));

    // Reserved positions never read as one (R5).
    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & UNIMPL) == '0);
endmodule

// File: rtl/irq_status_reg.sv
// Module: irq_status_reg
// Interrupt status register. Event pulses set bits, and software clears
// bits by writing ones. An event in the same cycle as a clear wins.
// Assumes: events are single-cycle pulses from the controller core.
module irq_status_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] status_q
);
    localparam logic [W-1:0] UNIMPL = ~IMPL_MASK;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic bit_q;
            // Per-bit update: reset, then event priority, then clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                     bit_q <= 1'b0;
                else if (evt[b])                bit_q <= 1'b1;
                else if (clr_we && clr_data[b]) bit_q <= 1'b0;
            end
            assign status_q[b] = bit_q;
        end else begin : g_rsvd
            assign status_q[b] = 1'b0;
        end
    end

    // Events on implemented bits are captured (R7, R8).
    assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt & IMPL_MASK) |=> ((status_q & $past(evt & IMPL_MASK)) == $past(evt & IMPL_MASK)));

    // Cleared bits without an event drop (R8).
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~evt)) == '0));

    // Reserved positions stay zero (R5).
    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & UNIMPL) == '0);
endmodule

// File: rtl/irq_request_gen.sv
// Module: irq_request_gen
// Produces the registered interrupt request from status, enable mask and
// the master enable bit.
// Assumes: the status register holds no bit at MASTER_BIT.
module irq_request_gen #(
    parameter int W          = 32,
    parameter int MASTER_BIT = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         irq_q
);
    logic pending;

    // Any enabled source currently flagged.
    always_comb pending = |(status & enable);

    // Register the gated request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending && enable[MASTER_BIT];
    end

    // Master off in the prior cycle means no request now (R6).
    assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable[MASTER_BIT]) |-> !irq_q);

    // Request follows the previous cycle's condition (R9).
    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == $past(enable[MASTER_BIT] && |(status & enable)));
endmodule

// File: rtl/usb_irq_mask_ctrl.sv
// Module: usb_irq_mask_ctrl (top)
// Interrupt enable set/clear controller. It ties together the enable mask,
// the status register and the request generator, and provides a
// combinational read mux.
// Assumes: synchronous active-low reset held for at least two clocks.
module usb_irq_mask_ctrl
    import usb_irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_we,
    input  logic [REG_W-1:0]  en_set_data,
    input  logic              en_clr_we,
    input  logic [REG_W-1:0]  en_clr_data,
    input  logic              st_clr_we,
    input  logic [REG_W-1:0]  st_clr_data,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_o
);
    logic [REG_W-1:0] mask_w;
    logic [REG_W-1:0] status_w;

    irq_enable_reg #(.W(REG_W), .IMPL_MASK(MASK_BITS)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (en_set_we),
        .set_data (en_set_data),
        .clr_we   (en_clr_we),
        .clr_data (en_clr_data),
        .mask_q   (mask_w)
    );

    irq_status_reg #(.W(REG_W), .IMPL_MASK(SRC_BITS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_we   (st_clr_we),
        .clr_data (st_clr_data),
        .status_q (status_w)
    );

    irq_request_gen #(.W(REG_W), .MASTER_BIT(MASTER_BIT)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_w),
        .enable (mask_w),
        .irq_q  (irq_o)
    );

    // Read mux: select status or mask.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_ENABLE: rd_data = mask_w;
            default:   rd_data = status_w;
        endcase
    end

    // Reset leaves everything clear (R1).
    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) && !rst_n |-> (mask_w == '0 && status_w == '0 && !irq_o));
endmodule

// File: tb/usb_irq_mask_ctrl_tb_top.sv
module usb_irq_mask_ctrl_tb_top;
    localparam logic [31:0] SRC  = 32'h4000_007F;
    localparam logic [31:0] MSK  = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set_we = 1'b0, en_clr_we = 1'b0, st_clr_we = 1'b0;
    logic [31:0] en_set_data = '0, en_clr_data = '0, st_clr_data = '0, evt_i = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [31:0] m_en = '0, m_st = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    usb_irq_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .en_set_we(en_set_we), .en_set_data(en_set_data),
        .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
        .st_clr_we(st_clr_we), .st_clr_data(st_clr_data),
        .evt_i(evt_i), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] next_en(logic [31:0] en, logic sw, logic [31:0] sd,
                                            logic cw, logic [31:0] cd);
        logic [31:0] r = en;
        if (sw) r = r | sd;
        if (cw) r = r & ~cd;
        return r & MSK;
    endfunction

    function automatic logic [31:0] next_st(logic [31:0] st, logic [31:0] ev,
                                            logic cw, logic [31:0] cd);
        logic [31:0] r = st;
        if (cw) r = r & ~cd;
        r = r | ev;
        return r & SRC;
    endfunction

    function automatic logic next_irq(logic [31:0] st, logic [31:0] en);
        return (|(st & en)) && en[31];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, then sample at the negedge.
    task automatic step(logic sw, logic [31:0] sd, logic cw, logic [31:0] cd,
                        logic tw, logic [31:0] td, logic [31:0] ev);
        en_set_we = sw; en_set_data = sd; en_clr_we = cw; en_clr_data = cd;
        st_clr_we = tw; st_clr_data = td; evt_i = ev;
        @(posedge clk);
        m_irq = next_irq(m_st, m_en);
        m_en  = next_en(m_en, sw, sd, cw, cd);
        m_st  = next_st(m_st, ev, tw, td);
        @(negedge clk);
        en_set_we = 0; en_clr_we = 0; st_clr_we = 0; evt_i = '0;
    endtask

    task automatic compare_all(string tag);
        rd_sel = 1'b1; #1;
        check({tag, " mask R10"}, rd_data, m_en);
        rd_sel = 1'b0; #1;
        check({tag, " status R10"}, rd_data, m_st);
        check({tag, " irq R9"}, {31'b0, irq_o}, {31'b0, m_irq});
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0, '0, '0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R1: reset state
        rd_sel = 1'b1; #1; check("R1 mask", rd_data, '0);
        rd_sel = 1'b0; #1; check("R1 status", rd_data, '0);
        check("R1 irq", {31'b0, irq_o}, '0);
        rst_n = 1'b1;

        // R2: set port sets ones, leaves zeros
        step(1, 32'h0000_0005, 0, '0, 0, '0, '0); compare_all("R2a");
        step(1, 32'h0000_0002, 0, '0, 0, '0, '0); compare_all("R2b");
        rd_sel = 1; #1; check("R2 accumulate", rd_data, 32'h0000_0007);
        step(1, 32'h0000_0000, 0, '0, 0, '0, '0);
        rd_sel = 1; #1; check("R2 zero write", rd_data, 32'h0000_0007);

        // R3: clear port
        step(0, '0, 1, 32'h0000_0004, 0, '0, '0);
        rd_sel = 1; #1; check("R3 clear", rd_data, 32'h0000_0003);

        // R4: collision, clear wins
        step(1, 32'h0000_0010, 1, 32'h0000_0010, 0, '0, '0);
        rd_sel = 1; #1; check("R4 clear wins", rd_data, 32'h0000_0003);

        // R5: reserved bits ignored everywhere
        step(1, 32'hFFFF_FFFF, 0, '0, 0, '0, 32'hFFFF_FFFF);
        rd_sel = 1; #1; check("R5 mask rsvd", rd_data, MSK);
        rd_sel = 0; #1; check("R5 status rsvd", rd_data, SRC);
        step(0, '0, 1, 32'h3FFF_FF80, 1, 32'hBFFF_FF80, '0);
        rd_sel = 1; #1; check("R5 mask after rsvd clear", rd_data, MSK);
        rd_sel = 0; #1; check("R5 status after rsvd clear", rd_data, SRC);

        // R6: master off blocks the request
        step(0, '0, 1, 32'h8000_0000, 0, '0, '0);
        idle(); idle();
        check("R6 master gate", {31'b0, irq_o}, '0);
        // R9: master on raises irq one cycle later
        step(1, 32'h8000_0000, 0, '0, 0, '0, '0);
        check("R9 lag", {31'b0, irq_o}, '0);
        idle();
        check("R9 raised", {31'b0, irq_o}, 32'h1);

        // R8: W1C on status, event wins collision
        step(0, '0, 0, '0, 1, SRC, 32'h0000_0020);
        rd_sel = 0; #1; check("R8 event wins", rd_data, 32'h0000_0020);
        step(0, '0, 0, '0, 1, 32'h0000_0020, '0);
        rd_sel = 0; #1; check("R8 w1c", rd_data, '0);
        idle();
        check("R9 drop", {31'b0, irq_o}, '0);

        // R7: event pulse sets and persists
        step(0, '0, 0, '0, 0, '0, 32'h4000_0000);
        idle(); idle();
        rd_sel = 0; #1; check("R7 persist", rd_data, 32'h4000_0000);
        compare_all("R7");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ev;
            ev = (($urandom % 4) == 0) ? ($urandom & $urandom) : '0;
            step(($urandom % 3) == 0, $urandom & $urandom,
                 ($urandom % 4) == 0, $urandom & $urandom,
                 ($urandom % 4) == 0, $urandom,
                 ev);
            compare_all("rand");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule